// File: doc/BRIEF.md
# Acquisition Status and Interrupt Controller

This block collects the event and error conditions of an acquisition timing engine into sticky status flags and folds them into a single interrupt request. Start-type triggers, stop triggers, scan-count terminal counts (TC) and pre-wait rollovers arrive as one-cycle pulses from the sequencer. Error conditions come from three places: the FIFO write path, the converter, and a scan-window tracker that watches sample-clock and last-convert pulses. A FIFO request level, picked by a two-bit condition code, joins them as one more interrupt source.

Software interacts through strobes only. One strobe vector turns interrupt enables on and a second turns them off. Per-flag acknowledge strobes clear single flags. A confirm strobe clears the TC error, and a clear-all strobe resets everything in one cycle. An optional halt-on-error input blocks converts and FIFO writes while any error flag stands. In pretrigger mode the first TC or TCs of a sequence are counted but kept silent.

Top module: `ist_status_ctrl`

## Requirements
- R1: Latched sources use these status bits: 0 start1, 1 start2, 2 start, 3 stop, 4 TC, 5 pre-wait rollover, 6 FIFO overflow, 7 conversion overrun, 8 scan overrun. A qualified event sets its bit on the next clock, and the bit holds until `ack_i` is strobed at the same index. If the event and its acknowledge come in the same cycle, the bit ends up set.
- R2: A start counts only while `seq_counting_i` is high, and it sets `scan_prog_o`. A stop counts only while `seq_counting_i` is high and `scan_prog_o` is already set, and it clears `scan_prog_o`. Bits 2 and 3 latch only for starts and stops that count.
- R3: A 1 on `en_set_i[k]` sets enable k and a 1 on `en_clr_i[k]` clears it, both taking effect on the next clock. When both are strobed together the clear wins. Neither strobe has any other effect.
- R4: `irq_o` is high exactly when some bit of `stat_o` and the same bit of `en_o` are both high.
- R5: A strobe on `ack_i[4]` clears the TC flag and `last_data_o` together. `last_data_o` is set by a pulse on `last_data_i`.
- R6: `tc_err_o` is set when a counted TC arrives while an earlier counted TC is still unacknowledged, unless a TC acknowledge comes in that same cycle. Only `tc_err_confirm_i` or the clear-all strobe clears it.
- R7: While `pretrig_i` is high, the first SKIP_TCS TCs after a clear-all or a start1 event are neither flagged nor treated as pending. When `pretrig_i` is low, every TC counts.
- R8: A scan overrun sets bit 8 when `sample_i` pulses while a scan is still open. A scan opens on a sample pulse and closes on a `last_cvt_i` pulse. A sample that arrives in the same cycle as the closing last convert is not an overrun.
- R9: Bit 6 sets when `fifo_wr_i` is high while `fifo_full_i` is high, and does not set while the FIFO is not full.
- R10: Status bit 9 is the FIFO request, registered one clock after the flags, with `fifo_mode_i` coded as follows. 0 means not empty. 1 means half full. 2 means full. 3 means the request rises at half full and stays up until the FIFO is empty.
- R11: While `halt_on_err_i` is high and any of bits 6, 7, 8 or `tc_err_o` is set, `convert_o` and `fifo_wr_o` are held low. Otherwise they follow `convert_i` and `fifo_wr_i`.
- R12: After reset, or one clock after `clr_all_i`, the following are all zero: every status bit, every enable, `tc_err_o`, `last_data_o`, `scan_prog_o` and the pretrigger TC count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_all_i | input | 1 | Clear-all strobe |
| seq_counting_i | input | 1 | Sequencer is in its counting state |
| pretrig_i | input | 1 | Pretrigger mode |
| ev_start1_i | input | 1 | Start1 event pulse |
| ev_start2_i | input | 1 | Start2 event pulse |
| ev_start_i | input | 1 | Start event pulse |
| ev_stop_i | input | 1 | Stop event pulse |
| ev_tc_i | input | 1 | Scan-count TC pulse |
| ev_prewait_i | input | 1 | Pre-wait rollover pulse |
| ev_overrun_i | input | 1 | Conversion overrun pulse |
| sample_i | input | 1 | Sample-clock pulse |
| last_cvt_i | input | 1 | Last convert of scan pulse |
| last_data_i | input | 1 | Last data written pulse |
| fifo_empty_i | input | 1 | FIFO empty |
| fifo_half_i | input | 1 | FIFO half full |
| fifo_full_i | input | 1 | FIFO full |
| fifo_mode_i | input | 2 | FIFO request condition |
| fifo_wr_i | input | 1 | FIFO write request in |
| convert_i | input | 1 | Convert pulse in |
| halt_on_err_i | input | 1 | Halt on error |
| en_set_i | input | 10 | Enable set strobes |
| en_clr_i | input | 10 | Enable clear strobes |
| ack_i | input | 9 | Flag acknowledge strobes |
| tc_err_confirm_i | input | 1 | TC error confirm strobe |
| stat_o | output | 10 | Status bits (9 = FIFO request) |
| en_o | output | 10 | Interrupt enables |
| tc_err_o | output | 1 | TC error |
| last_data_o | output | 1 | Last data written flag |
| scan_prog_o | output | 1 | Scan in progress |
| irq_o | output | 1 | Combined interrupt request |
| convert_o | output | 1 | Gated convert |
| fifo_wr_o | output | 1 | Gated FIFO write |

## Verification
An event pulse and the acknowledge for the same flag can land in the same cycle. The bench provokes this for every latched source by strobing the acknowledge on the event's own clock, and it expects the flag to read set afterwards. For TC the same overlap also decides the error flag. The bench acknowledges the first TC in the cycle of a following TC and expects no error, then sends an unacknowledged pair and expects the error. A sample-clock pulse can also coincide with the last convert of the open scan, and that case is judged as not being an overrun.

// File: rtl/ist_pkg.sv
package ist_pkg;
   localparam int NFLAG = 9;
   localparam int NSRC  = NFLAG + 1;

   localparam int SRC_START1  = 0;
   localparam int SRC_START2  = 1;
   localparam int SRC_START   = 2;
   localparam int SRC_STOP    = 3;
   localparam int SRC_TC      = 4;
   localparam int SRC_PREWAIT = 5;
   localparam int SRC_OVFL    = 6;
   localparam int SRC_OVRUN   = 7;
   localparam int SRC_SCANOVR = 8;
   localparam int SRC_FIFO    = 9;

   typedef enum logic [1:0] {
      FQ_NOT_EMPTY     = 2'd0,
      FQ_HALF          = 2'd1,
      FQ_FULL          = 2'd2,
      FQ_HALF_TO_EMPTY = 2'd3
   } fifo_cond_e;
endpackage

// File: rtl/ist_flag_bank.sv
module ist_flag_bank #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] ack_i,
   output logic [W-1:0] flag_o
);
   if (W < 1) begin : g_bad_w
      $error("ist_flag_bank: W must be at least 1");
   end

   for (genvar k = 0; k < W; k++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q <= 1'b0;
         else if (clr_i)      q <= 1'b0;
         else if (set_i[k])   q <= 1'b1;
         else if (ack_i[k])   q <= 1'b0;
      end
      assign flag_o[k] = q;

      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_o[k] && !ack_i[k] && !clr_i) |=> flag_o[k]); // R1
      AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i[k] && !clr_i) |=> flag_o[k]); // R1
   end
endmodule

// File: rtl/ist_tc_track.sv
module ist_tc_track #(
   parameter int SKIP_TCS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic pretrig_i,
   input  logic rearm_i,
   input  logic ev_tc_i,
   input  logic ack_i,
   input  logic confirm_i,
   output logic tc_set_o,
   output logic tc_err_o
);
   localparam int CW = (SKIP_TCS < 1) ? 1 : $clog2(SKIP_TCS + 1);

   if (SKIP_TCS < 0 || SKIP_TCS > 255) begin : g_bad_skip
      $error("ist_tc_track: SKIP_TCS out of range");
   end

   logic suppress;

   if (SKIP_TCS == 0) begin : g_noskip
      assign suppress = 1'b0;
   end else begin : g_skip
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           cnt_q <= '0;
         else if (clr_i || rearm_i)            cnt_q <= '0;
         else if (ev_tc_i && suppress)         cnt_q <= cnt_q + 1'b1;
      end
      assign suppress = pretrig_i && (cnt_q < CW'(SKIP_TCS));
   end

   logic pend_q, err_q;
   assign tc_set_o = ev_tc_i && !suppress;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (clr_i) begin
         pend_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (tc_set_o)      pend_q <= 1'b1;
         else if (ack_i)    pend_q <= 1'b0;
         if (tc_set_o && pend_q && !ack_i) err_q <= 1'b1;
         else if (confirm_i)               err_q <= 1'b0;
      end
   end
   assign tc_err_o = err_q;

   AST_TC_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_err_o && !confirm_i && !clr_i) |=> tc_err_o); // R6
   AST_TC_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_err_o) |-> $past(ev_tc_i)); // R6
   AST_NOPRE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tc_i && !pretrig_i) |-> tc_set_o); // R7
endmodule

// File: rtl/ist_fifo_req.sv
module ist_fifo_req
   import ist_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic [1:0] mode_i,
   input  logic       empty_i,
   input  logic       half_i,
   input  logic       full_i,
   output logic       req_o
);
   fifo_cond_e mode;
   logic       req_q, req_d;

   assign mode = fifo_cond_e'(mode_i);

   always_comb begin
      unique case (mode)
         FQ_NOT_EMPTY:     req_d = !empty_i;
         FQ_HALF:          req_d = half_i;
         FQ_FULL:          req_d = full_i;
         FQ_HALF_TO_EMPTY: req_d = req_q ? !empty_i : half_i;
         default:          req_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      req_q <= 1'b0;
      else if (clr_i)  req_q <= 1'b0;
      else             req_q <= req_d;
   end
   assign req_o = req_q;

   AST_MODE3_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd3 && req_o && !empty_i && !clr_i) |=> req_o); // R10
   AST_EMPTY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd0 && empty_i) |=> !req_o); // R10
endmodule

// File: rtl/ist_status_ctrl.sv
module ist_status_ctrl
   import ist_pkg::*;
#(
   parameter int SKIP_TCS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all_i,
   input  logic             seq_counting_i,
   input  logic             pretrig_i,
   input  logic             ev_start1_i,
   input  logic             ev_start2_i,
   input  logic             ev_start_i,
   input  logic             ev_stop_i,
   input  logic             ev_tc_i,
   input  logic             ev_prewait_i,
   input  logic             ev_overrun_i,
   input  logic             sample_i,
   input  logic             last_cvt_i,
   input  logic             last_data_i,
   input  logic             fifo_empty_i,
   input  logic             fifo_half_i,
   input  logic             fifo_full_i,
   input  logic [1:0]       fifo_mode_i,
   input  logic             fifo_wr_i,
   input  logic             convert_i,
   input  logic             halt_on_err_i,
   input  logic [NSRC-1:0]  en_set_i,
   input  logic [NSRC-1:0]  en_clr_i,
   input  logic [NFLAG-1:0] ack_i,
   input  logic             tc_err_confirm_i,
   output logic [NSRC-1:0]  stat_o,
   output logic [NSRC-1:0]  en_o,
   output logic             tc_err_o,
   output logic             last_data_o,
   output logic             scan_prog_o,
   output logic             irq_o,
   output logic             convert_o,
   output logic             fifo_wr_o
);
   logic             valid_start, valid_stop, tc_set, scan_ovr, overflow;
   logic             scan_q, busy_q, last_q, fifo_req, block;
   logic [NFLAG-1:0] set_vec, flags;
   logic [NSRC-1:0]  en_q;

   assign valid_start = ev_start_i && seq_counting_i;
   assign valid_stop  = ev_stop_i && seq_counting_i && scan_q;
   assign scan_ovr    = sample_i && busy_q && !last_cvt_i;
   assign overflow    = fifo_wr_i && fifo_full_i;

   always_comb begin
      set_vec              = '0;
      set_vec[SRC_START1]  = ev_start1_i;
      set_vec[SRC_START2]  = ev_start2_i;
      set_vec[SRC_START]   = valid_start;
      set_vec[SRC_STOP]    = valid_stop;
      set_vec[SRC_TC]      = tc_set;
      set_vec[SRC_PREWAIT] = ev_prewait_i;
      set_vec[SRC_OVFL]    = overflow;
      set_vec[SRC_OVRUN]   = ev_overrun_i;
      set_vec[SRC_SCANOVR] = scan_ovr;
   end

   ist_flag_bank #(.W(NFLAG)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_all_i),
      .set_i  (set_vec),
      .ack_i  (ack_i),
      .flag_o (flags)
   );

   ist_tc_track #(.SKIP_TCS(SKIP_TCS)) u_tc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr_all_i),
      .pretrig_i (pretrig_i),
      .rearm_i   (ev_start1_i),
      .ev_tc_i   (ev_tc_i),
      .ack_i     (ack_i[SRC_TC]),
      .confirm_i (tc_err_confirm_i),
      .tc_set_o  (tc_set),
      .tc_err_o  (tc_err_o)
   );

   ist_fifo_req u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_all_i),
      .mode_i  (fifo_mode_i),
      .empty_i (fifo_empty_i),
      .half_i  (fifo_half_i),
      .full_i  (fifo_full_i),
      .req_o   (fifo_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_q <= 1'b0;
         busy_q <= 1'b0;
         last_q <= 1'b0;
         en_q   <= '0;
      end else if (clr_all_i) begin
         scan_q <= 1'b0;
         busy_q <= 1'b0;
         last_q <= 1'b0;
         en_q   <= '0;
      end else begin
         if (valid_start)     scan_q <= 1'b1;
         else if (valid_stop) scan_q <= 1'b0;
         if (sample_i)        busy_q <= 1'b1;
         else if (last_cvt_i) busy_q <= 1'b0;
         if (last_data_i)         last_q <= 1'b1;
         else if (ack_i[SRC_TC])  last_q <= 1'b0;
         en_q <= (en_q | en_set_i) & ~en_clr_i;
      end
   end

   assign stat_o      = {fifo_req, flags};
   assign en_o        = en_q;
   assign scan_prog_o = scan_q;
   assign last_data_o = last_q;
   assign irq_o       = |(stat_o & en_q);

   assign block     = halt_on_err_i &&
                      (tc_err_o || flags[SRC_OVFL] || flags[SRC_OVRUN] || flags[SRC_SCANOVR]);
   assign convert_o = convert_i && !block;
   assign fifo_wr_o = fifo_wr_i && !block;

   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_all_i) |=> ((en_o & ($past(en_set_i) & ~$past(en_clr_i)))
                        == ($past(en_set_i) & ~$past(en_clr_i)))); // R3
   AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((en_o & $past(en_clr_i)) == '0)); // R3
   AST_SCAN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_prog_o) |-> ($past(clr_all_i) || $past(ev_stop_i && seq_counting_i))); // R2
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (en_o != '0)); // R4
   AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_on_err_i && (tc_err_o || stat_o[8:6] != '0)) |-> (!convert_o && !fifo_wr_o)); // R11
   AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all_i |=> (stat_o == '0 && en_o == '0 && !tc_err_o && !scan_prog_o && !last_data_o)); // R12
endmodule

// File: tb/ist_status_ctrl_tb.sv
module ist_status_ctrl_tb;
   import ist_pkg::*;
   localparam int CLK_PERIOD = 10;
   localparam int TIMEOUT_CYC = 20000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic clr_all_i = 0, seq_counting_i = 0, pretrig_i = 0;
   logic ev_start1_i = 0, ev_start2_i = 0, ev_start_i = 0, ev_stop_i = 0;
   logic ev_tc_i = 0, ev_prewait_i = 0, ev_overrun_i = 0;
   logic sample_i = 0, last_cvt_i = 0, last_data_i = 0;
   logic fifo_empty_i = 1, fifo_half_i = 0, fifo_full_i = 0;
   logic [1:0] fifo_mode_i = 0;
   logic fifo_wr_i = 0, convert_i = 0, halt_on_err_i = 0, tc_err_confirm_i = 0;
   logic [NSRC-1:0]  en_set_i = '0, en_clr_i = '0;
   logic [NFLAG-1:0] ack_i = '0;
   logic [NSRC-1:0]  stat_o, en_o;
   logic tc_err_o, last_data_o, scan_prog_o, irq_o, convert_o, fifo_wr_o;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ist_status_ctrl u_dut (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic clr_pulse();
      clr_all_i = 1; cyc(); clr_all_i = 0;
   endtask

   task automatic set_ev(int i, logic v);
      case (i)
         0: ev_start1_i  = v;
         1: ev_start2_i  = v;
         2: ev_start_i   = v;
         3: ev_stop_i    = v;
         4: ev_tc_i      = v;
         5: ev_prewait_i = v;
         6: begin fifo_wr_i = v; fifo_full_i = v; end
         7: ev_overrun_i = v;
         default: sample_i = v;
      endcase
   endtask

   task automatic fire(int i, bit with_ack);
      if (i == 3) begin ev_start_i = 1; cyc(); ev_start_i = 0; end
      if (i == 8) begin sample_i = 1; cyc(); end
      set_ev(i, 1);
      if (with_ack) ack_i = NFLAG'(1) << i;
      cyc();
      set_ev(i, 0);
      ack_i = '0;
   endtask

   task automatic pulse_tc();
      ev_tc_i = 1; cyc(); ev_tc_i = 0;
   endtask

   initial begin
      repeat (TIMEOUT_CYC) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      bit hold;
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      // R12 reset state
      check("R12 stat", 32'(stat_o), 0);
      check("R12 en", 32'(en_o), 0);
      check("R12 flags", {29'd0, tc_err_o, last_data_o, scan_prog_o}, 0);

      // R3 enable strobes
      en_set_i = '1; cyc(); en_set_i = '0;
      check("R3 set", 32'(en_o), 32'h3FF);
      en_clr_i = 10'h0A5; cyc(); en_clr_i = '0;
      check("R3 clr", 32'(en_o), 32'h35A);
      en_set_i = 10'h003; en_clr_i = 10'h001; cyc(); en_set_i = '0; en_clr_i = '0;
      check("R3 clr wins", 32'(en_o), 32'h35B & ~32'h1 | 32'h2);

      // R1 / R4 per source, including event+ack overlap
      seq_counting_i = 1;
      for (int i = 0; i < NFLAG; i++) begin
         clr_pulse();
         fire(i, 0);
         check("R1 set", 32'(stat_o[i]), 1);
         en_set_i = NSRC'(1) << i; cyc(); en_set_i = '0;
         check("R4 irq on", 32'(irq_o), 1);
         en_clr_i = NSRC'(1) << i; en_set_i = NSRC'(1) << SRC_FIFO; cyc();
         en_clr_i = '0; en_set_i = '0;
         check("R4 irq off", 32'(irq_o), 0);
         ack_i = NFLAG'(1) << i; cyc(); ack_i = '0;
         check("R1 ack", 32'(stat_o[i]), 0);
         fire(i, 1);
         check("R1 event wins", 32'(stat_o[i]), 1);
      end

      // R2 qualification
      clr_pulse();
      seq_counting_i = 0; ev_start_i = 1; cyc(); ev_start_i = 0;
      check("R2 start ignored", {30'd0, stat_o[SRC_START], scan_prog_o}, 0);
      seq_counting_i = 1; ev_stop_i = 1; cyc(); ev_stop_i = 0;
      check("R2 stop ignored", 32'(stat_o[SRC_STOP]), 0);
      ev_start_i = 1; cyc(); ev_start_i = 0;
      check("R2 scan set", 32'(scan_prog_o), 1);
      ev_stop_i = 1; cyc(); ev_stop_i = 0;
      check("R2 scan clr", {30'd0, stat_o[SRC_STOP], scan_prog_o}, 2);

      // R5 / R6
      clr_pulse();
      pulse_tc();
      last_data_i = 1; cyc(); last_data_i = 0;
      check("R5 last set", 32'(last_data_o), 1);
      ack_i[SRC_TC] = 1; cyc(); ack_i = '0;
      check("R5 ack", {30'd0, stat_o[SRC_TC], last_data_o}, 0);
      pulse_tc();
      ev_tc_i = 1; ack_i[SRC_TC] = 1; cyc(); ev_tc_i = 0; ack_i = '0;
      check("R6 ack same cycle", 32'(tc_err_o), 0);
      pulse_tc();
      check("R6 error", 32'(tc_err_o), 1);
      ack_i[SRC_TC] = 1; cyc(); ack_i = '0;
      check("R6 sticky", 32'(tc_err_o), 1);
      tc_err_confirm_i = 1; cyc(); tc_err_confirm_i = 0;
      check("R6 confirm", 32'(tc_err_o), 0);

      // R7 pretrigger suppression
      pretrig_i = 1; clr_pulse();
      pulse_tc();
      check("R7 first silent", 32'(stat_o[SRC_TC]), 0);
      pulse_tc();
      check("R7 second flags", {30'd0, stat_o[SRC_TC], tc_err_o}, 2);
      ev_start1_i = 1; ack_i[SRC_TC] = 1; cyc(); ev_start1_i = 0; ack_i = '0;
      pulse_tc();
      check("R7 rearmed", 32'(stat_o[SRC_TC]), 0);
      pretrig_i = 0;

      // R8 scan overrun corners
      clr_pulse();
      sample_i = 1; cyc(); sample_i = 0;
      last_cvt_i = 1; cyc(); last_cvt_i = 0;
      sample_i = 1; cyc(); sample_i = 0;
      check("R8 closed scan", 32'(stat_o[SRC_SCANOVR]), 0);
      sample_i = 1; last_cvt_i = 1; cyc(); sample_i = 0; last_cvt_i = 0;
      check("R8 same cycle", 32'(stat_o[SRC_SCANOVR]), 0);
      sample_i = 1; cyc(); sample_i = 0;
      check("R8 overrun", 32'(stat_o[SRC_SCANOVR]), 1);

      // R9 / R11
      clr_pulse();
      fifo_wr_i = 1; cyc(); fifo_wr_i = 0;
      check("R9 not full", 32'(stat_o[SRC_OVFL]), 0);
      convert_i = 1; fifo_wr_i = 1; halt_on_err_i = 1; #1;
      check("R11 pass", {30'd0, convert_o, fifo_wr_o}, 3);
      fifo_full_i = 1; cyc(); fifo_full_i = 0;
      check("R9 overflow", 32'(stat_o[SRC_OVFL]), 1);
      check("R11 blocked", {30'd0, convert_o, fifo_wr_o}, 0);
      halt_on_err_i = 0; #1;
      check("R11 no halt", {30'd0, convert_o, fifo_wr_o}, 3);
      convert_i = 0; fifo_wr_i = 0;

      // R10 FIFO request sweep
      clr_pulse();
      for (int m = 0; m < 3; m++) begin
         for (int c = 0; c < 4; c++) begin
            logic e, h, f, exp;
            e = (c == 0); h = (c >= 2); f = (c == 3);
            fifo_mode_i = 2'(m); fifo_empty_i = e; fifo_half_i = h; fifo_full_i = f;
            cyc();
            exp = (m == 0) ? !e : (m == 1) ? h : f;
            check("R10 level mode", 32'(stat_o[SRC_FIFO]), 32'(exp));
         end
      end
      fifo_mode_i = 2'd3; hold = 0;
      for (int s = 0; s < 8; s++) begin
         logic [3:0] seq [8] = '{4'd0, 4'd1, 4'd2, 4'd1, 4'd3, 4'd1, 4'd0, 4'd1};
         fifo_empty_i = (seq[s] == 0); fifo_half_i = (seq[s] >= 2); fifo_full_i = (seq[s] == 3);
         hold = hold ? !fifo_empty_i : fifo_half_i;
         cyc();
         check("R10 hysteresis", 32'(stat_o[SRC_FIFO]), 32'(hold));
      end
      fifo_mode_i = 0; fifo_empty_i = 1; fifo_half_i = 0; fifo_full_i = 0;

      // R12 clear-all
      en_set_i = '1; ev_start_i = 1; ev_overrun_i = 1; last_data_i = 1; cyc();
      en_set_i = '0; ev_start_i = 0; ev_overrun_i = 0; last_data_i = 0;
      pulse_tc(); pulse_tc();
      check("R12 pre", {28'd0, tc_err_o, last_data_o, scan_prog_o, stat_o[SRC_OVRUN]}, 15);
      clr_pulse();
      check("R12 stat", 32'(stat_o), 0);
      check("R12 en", 32'(en_o), 0);
      check("R12 misc", {29'd0, tc_err_o, last_data_o, scan_prog_o}, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule